// File: doc/BRIEF.md
# Offset Trim Binary-Search Calibrator

This block finds the offset trim code of one DAC output channel without software help. On an accepted start request it takes the channel out of service, waits a few cycles so the channel's ready state can fall, and forces the channel mode field to zero. It then enables the channel's calibration path and runs a successive-approximation search over a 5-bit trim code. The only feedback is one comparator flag from the analog side.

Every candidate code is held for a programmable number of cycles before the flag is sampled. Software sets that count so the analog minimum of 50 µs is met at whatever clock drives the block. Four halving steps are followed by one verification step, which may raise the code by one. The block then drops the calibration enable, writes back the mode value it saved, releases the channel and pulses done. The trim code stays on its output until the next run or a user write. Software may also load a trim code directly, and that code is then flagged as user-set.

Top module: `dac_trim_cal`

## Requirements
- R1: After reset the trim output is 0x10, and the calibration enable, channel disable, mode override, done, error and user-set outputs are all low.
- R2: A start request sampled while `chan_busy_i` is high raises `err_o` for exactly one cycle, starting in the cycle after that edge. No calibration begins, so the channel disable and calibration enable stay low.
- R3: An accepted start raises `chan_off_o` in the next cycle. `cal_en_o` rises DROP_CYC cycles after that. For the whole time `cal_en_o` is high, `mode_ovr_o` is high, `mode_val_o` is zero and `chan_off_o` is high.
- R4: The search starts at code 0x10 with a step of 0x08, and the step halves after each decision down to 1. A high comparator flag subtracts the step from the code and a low flag adds it, so with a flag that is high when code >= 11 the candidates are 16, 8, 12, 10, 11.
- R5: Each candidate code, including the first, is held for `settle_i` + 1 clock cycles before the flag is sampled. A full run takes DROP_CYC + 5·(`settle_i` + 1) + 1 cycles from the start edge to the cycle in which `done_o` is high.
- R6: After the last halving step, the final code is held for one more settle period and checked again. If the flag is then low and the code is below 0x1F, the code is incremented by one.
- R7: With a comparator flag that is high exactly when code >= T, the final trim code for every T from 0 to 32 equals T clamped to the range 1..31.
- R8: At the end of a run `done_o` is high for exactly one cycle. In that cycle `cal_en_o` and `chan_off_o` are low, and `mode_ovr_o` is high with `mode_val_o` equal to the `mode_i` value captured at start. The final code stays on `trim_o` afterwards.
- R9: A `user_wr_i` pulse while the block is idle loads `user_code_i` into `trim_o` on the next cycle and sets `user_set_o`. An accepted start clears `user_set_o`.
- R10: During a run, start requests and user trim writes are ignored. The search result is unchanged, `err_o` stays low and `user_set_o` stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Calibration request |
| cmp_i | input | 1 | Comparator flag; high means the code is too high |
| chan_busy_i | input | 1 | Channel is busy; a start is refused |
| settle_i | input | CNT_W | Settle count; each code is held settle_i+1 cycles |
| mode_i | input | MODE_W | Current channel mode field, saved at start |
| user_wr_i | input | 1 | User trim write strobe |
| user_code_i | input | CODE_W | User trim code |
| trim_o | output | CODE_W | Trim code to the analog trim circuit |
| cal_en_o | output | 1 | Calibration enable for the channel |
| chan_off_o | output | 1 | Forces the channel disabled |
| mode_ovr_o | output | 1 | Mode field override is active |
| mode_val_o | output | MODE_W | Mode value driven while overriding |
| done_o | output | 1 | One-cycle calibration-finished pulse |
| err_o | output | 1 | One-cycle start-refused pulse |
| user_set_o | output | 1 | Trim code came from a user write |

## Verification
The comparator is modelled as a threshold on the trim code, and the threshold is swept over every value from 0 to 32. The closed-form result, the threshold clamped to 1..31, separates correct add/subtract directions and step halving from off-by-one errors. It also separates a verification bump that fires correctly from one that is missing, fires always, or wraps at the top. The settle count is varied over 0 to 3, so the hold length and the total run length catch a timer that reloads or compares wrongly. Separate runs with the channel busy, with a user write before the run, and with start and write pokes during a run cover refusal, the user-set flag and the ignore rules.

// File: rtl/dac_trim_cal_pkg.sv
package dac_trim_cal_pkg;
  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_DROP   = 2'd1,
    ST_SETTLE = 2'd2,
    ST_FINISH = 2'd3
  } cal_state_e;
endpackage

// File: rtl/trim_settle_timer.sv
module trim_settle_timer #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load_i,
  input  logic [CNT_W-1:0] value_i,
  input  logic             run_i,
  output logic             expired_o
);
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             cnt_en;

  always_comb begin
    cnt_en = 1'b0;
    cnt_d  = cnt_q;
    if (load_i) begin
      cnt_en = 1'b1;
      cnt_d  = value_i;
    end else if (run_i && (cnt_q != '0)) begin
      cnt_en = 1'b1;
      cnt_d  = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign expired_o = (cnt_q == '0);

  // A load of a non-zero value must leave the timer unexpired
  assert_load_arms_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (load_i && (value_i != '0)) |=> !expired_o);
endmodule

// File: rtl/trim_sar_step.sv
module trim_sar_step #(
  parameter int CODE_W = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              init_i,
  input  logic              step_i,
  input  logic              final_i,
  input  logic              cmp_i,
  input  logic              user_ld_i,
  input  logic [CODE_W-1:0] user_code_i,
  output logic [CODE_W-1:0] code_o,
  output logic              last_o
);
  localparam logic [CODE_W-1:0] MID_CODE  = {1'b1, {(CODE_W-1){1'b0}}};
  localparam logic [CODE_W-1:0] MAX_CODE  = {CODE_W{1'b1}};
  localparam logic [CODE_W-1:0] FIRST_DLT = MID_CODE >> 1;

  logic [CODE_W-1:0] code_q, code_d;
  logic [CODE_W-1:0] delta_q, delta_d;
  logic              reg_en;

  always_comb begin
    reg_en  = 1'b0;
    code_d  = code_q;
    delta_d = delta_q;
    if (init_i) begin
      reg_en  = 1'b1;
      code_d  = MID_CODE;
      delta_d = FIRST_DLT;
    end else if (step_i) begin
      reg_en  = 1'b1;
      code_d  = cmp_i ? (code_q - delta_q) : (code_q + delta_q);
      delta_d = delta_q >> 1;
    end else if (final_i) begin
      reg_en = 1'b1;
      if (!cmp_i && (code_q != MAX_CODE)) code_d = code_q + 1'b1;
    end else if (user_ld_i) begin
      reg_en = 1'b1;
      code_d = user_code_i;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q  <= MID_CODE;
      delta_q <= '0;
    end else if (reg_en) begin
      code_q  <= code_d;
      delta_q <= delta_d;
    end
  end

  assign code_o = code_q;
  assign last_o = (delta_q == '0);

  // A halving step is only requested while a non-zero step remains
  assert_step_live_R4: assert property (@(posedge clk) disable iff (!rst_n)
    step_i |-> (delta_q != '0));
  // A downward step never goes below zero
  assert_no_underflow_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (step_i && cmp_i) |-> (code_q > delta_q));
  // The verification bump never wraps the top code
  assert_no_wrap_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (final_i && (code_q == MAX_CODE)) |=> (code_q == MAX_CODE));
endmodule

// File: rtl/dac_trim_cal.sv
module dac_trim_cal
  import dac_trim_cal_pkg::*;
#(
  parameter int CODE_W   = 5,
  parameter int CNT_W    = 16,
  parameter int MODE_W   = 3,
  parameter int DROP_CYC = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_i,
  input  logic              cmp_i,
  input  logic              chan_busy_i,
  input  logic [CNT_W-1:0]  settle_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic              user_wr_i,
  input  logic [CODE_W-1:0] user_code_i,
  output logic [CODE_W-1:0] trim_o,
  output logic              cal_en_o,
  output logic              chan_off_o,
  output logic              mode_ovr_o,
  output logic [MODE_W-1:0] mode_val_o,
  output logic              done_o,
  output logic              err_o,
  output logic              user_set_o
);
  localparam int            DROP_W  = $clog2(DROP_CYC) + 1;
  localparam logic [DROP_W-1:0] DROP_LD = DROP_W'(DROP_CYC - 1);

  cal_state_e        state_q, state_d;
  logic              cal_en_q, cal_en_d;
  logic              err_q, err_d;
  logic              user_set_q, user_set_d;
  logic [MODE_W-1:0] saved_q;
  logic              save_en;
  logic              accept;
  logic              drop_load, drop_exp;
  logic              settle_load, settle_exp;
  logic              sar_init, sar_step, sar_final, sar_last, user_ld;

  // Next-state and control decode
  always_comb begin
    state_d     = state_q;
    cal_en_d    = cal_en_q;
    err_d       = 1'b0;
    accept      = 1'b0;
    drop_load   = 1'b0;
    settle_load = 1'b0;
    sar_init    = 1'b0;
    sar_step    = 1'b0;
    sar_final   = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          if (chan_busy_i) begin
            err_d = 1'b1;
          end else begin
            accept    = 1'b1;
            drop_load = 1'b1;
            state_d   = ST_DROP;
          end
        end
      end
      ST_DROP: begin
        if (drop_exp) begin
          sar_init    = 1'b1;
          settle_load = 1'b1;
          cal_en_d    = 1'b1;
          state_d     = ST_SETTLE;
        end
      end
      ST_SETTLE: begin
        if (settle_exp) begin
          if (sar_last) begin
            sar_final = 1'b1;
            cal_en_d  = 1'b0;
            state_d   = ST_FINISH;
          end else begin
            sar_step    = 1'b1;
            settle_load = 1'b1;
          end
        end
      end
      ST_FINISH: state_d = ST_IDLE;
      default:   state_d = ST_IDLE;
    endcase
  end

  assign save_en    = accept;
  assign user_ld    = (state_q == ST_IDLE) && user_wr_i;
  assign user_set_d = accept ? 1'b0 : (user_ld ? 1'b1 : user_set_q);

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      cal_en_q   <= 1'b0;
      err_q      <= 1'b0;
      user_set_q <= 1'b0;
    end else begin
      state_q    <= state_d;
      cal_en_q   <= cal_en_d;
      err_q      <= err_d;
      user_set_q <= user_set_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       saved_q <= '0;
    else if (save_en) saved_q <= mode_i;
  end

  trim_settle_timer #(.CNT_W(DROP_W)) u_drop_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (drop_load),
    .value_i   (DROP_LD),
    .run_i     (state_q == ST_DROP),
    .expired_o (drop_exp)
  );

  trim_settle_timer #(.CNT_W(CNT_W)) u_settle_timer (
    .clk       (clk),
    .rst_n     (rst_n),
    .load_i    (settle_load),
    .value_i   (settle_i),
    .run_i     (state_q == ST_SETTLE),
    .expired_o (settle_exp)
  );

  trim_sar_step #(.CODE_W(CODE_W)) u_sar (
    .clk         (clk),
    .rst_n       (rst_n),
    .init_i      (sar_init),
    .step_i      (sar_step),
    .final_i     (sar_final),
    .cmp_i       (cmp_i),
    .user_ld_i   (user_ld),
    .user_code_i (user_code_i),
    .code_o      (trim_o),
    .last_o      (sar_last)
  );

  assign cal_en_o   = cal_en_q;
  assign chan_off_o = (state_q == ST_DROP) || (state_q == ST_SETTLE);
  assign mode_ovr_o = (state_q == ST_SETTLE) || (state_q == ST_FINISH);
  assign mode_val_o = (state_q == ST_FINISH) ? saved_q : '0;
  assign done_o     = (state_q == ST_FINISH);
  assign err_o      = err_q;
  assign user_set_o = user_set_q;

  // A candidate code is not disturbed before its settle period ends
  assert_hold_code_R5: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_SETTLE) && !settle_exp) |=> $stable(trim_o));
  // An error pulse always follows a start that met a busy channel
  assert_err_cause_R2: assert property (@(posedge clk) disable iff (!rst_n)
    err_o |-> $past(start_i && chan_busy_i));
  // Calibration runs only with the channel disabled and mode forced to zero
  assert_cal_guard_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cal_en_o |-> (chan_off_o && mode_ovr_o && (mode_val_o == '0)));
  // Done comes with the calibration path already off and lasts one cycle
  assert_done_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
    done_o |-> (!cal_en_o && !chan_off_o) ##1 !done_o);
endmodule

// File: tb/dac_trim_cal_test.sv
module dac_trim_cal_test;
  localparam int CW = 5;
  localparam int NW = 16;
  localparam int MW = 3;
  localparam int D  = 3;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          start_i = 1'b0;
  logic          cmp_i;
  logic          chan_busy_i = 1'b0;
  logic [NW-1:0] settle_i = '0;
  logic [MW-1:0] mode_i = '0;
  logic          user_wr_i = 1'b0;
  logic [CW-1:0] user_code_i = '0;
  logic [CW-1:0] trim_o;
  logic          cal_en_o, chan_off_o, mode_ovr_o, done_o, err_o, user_set_o;
  logic [MW-1:0] mode_val_o;

  int tests = 0;
  int fails = 0;
  int target = 0;
  int wd = 0;

  always #10 clk = ~clk;

  assign cmp_i = (int'(trim_o) >= target);

  dac_trim_cal #(.CODE_W(CW), .CNT_W(NW), .MODE_W(MW), .DROP_CYC(D)) uut (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .cmp_i(cmp_i),
    .chan_busy_i(chan_busy_i), .settle_i(settle_i), .mode_i(mode_i),
    .user_wr_i(user_wr_i), .user_code_i(user_code_i), .trim_o(trim_o),
    .cal_en_o(cal_en_o), .chan_off_o(chan_off_o), .mode_ovr_o(mode_ovr_o),
    .mode_val_o(mode_val_o), .done_o(done_o), .err_o(err_o), .user_set_o(user_set_o)
  );

  always @(posedge clk) begin
    wd <= wd + 1;
    if (wd > 150000) begin
      fails = fails + 1;
      tests = tests + 1;
      $display("FAIL watchdog (all requirements): actual %0d cycles, expected below 150000", wd);
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    tests = tests + 1;
    if (!ok) begin
      fails = fails + 1;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  // Results of the last run
  int  r_code, r_cyc, r_chan_at, r_cal_at, r_first, r_nseq;
  int  r_seq[8];
  bit  r_ovr_ok, r_err_seen, r_usr_seen;
  int  r_done_mode, r_done_ovr, r_done_cal, r_done_off, r_done_after;

  task automatic run_cal(input int tgt, input int s, input logic [MW-1:0] md, input bit poke);
    target   = tgt;
    settle_i = NW'(s);
    mode_i   = md;
    r_cyc = 0; r_chan_at = -1; r_cal_at = -1; r_first = -1; r_nseq = 0;
    r_ovr_ok = 1'b1; r_err_seen = 1'b0; r_usr_seen = 1'b0; r_code = -1;
    @(negedge clk);
    start_i = 1'b1;
    while (r_cyc < 4000) begin
      @(posedge clk);
      r_cyc++;
      @(negedge clk);
      start_i   = 1'b0;
      user_wr_i = 1'b0;
      if (poke && (r_cyc == D + 3 || r_cyc == D + 2 + s)) begin
        start_i     = 1'b1;
        user_wr_i   = 1'b1;
        user_code_i = 5'd0;
      end
      if (err_o) r_err_seen = 1'b1;
      if (user_set_o) r_usr_seen = 1'b1;
      if (chan_off_o && r_chan_at < 0) r_chan_at = r_cyc;
      if (cal_en_o) begin
        if (!(mode_ovr_o && mode_val_o == '0 && chan_off_o)) r_ovr_ok = 1'b0;
        if (r_cal_at < 0) begin
          r_cal_at = r_cyc; r_seq[0] = int'(trim_o); r_nseq = 1;
        end else if (int'(trim_o) != r_seq[r_nseq-1] && r_nseq < 8) begin
          if (r_first < 0) r_first = r_cyc;
          r_seq[r_nseq] = int'(trim_o); r_nseq++;
        end
      end
      if (done_o) begin
        r_code = int'(trim_o);
        r_done_mode = int'(mode_val_o); r_done_ovr = int'(mode_ovr_o);
        r_done_cal = int'(cal_en_o); r_done_off = int'(chan_off_o);
        break;
      end
    end
    start_i = 1'b0; user_wr_i = 1'b0;
    @(posedge clk);
    @(negedge clk);
    r_done_after = int'(done_o);
  endtask

  initial begin
    int exp_code;
    int exp_seq[5];
    exp_seq = '{16, 8, 12, 10, 11};
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    check(trim_o == 5'h10, "R1 trim reset", int'(trim_o), 16);
    check({cal_en_o, chan_off_o, mode_ovr_o, done_o, err_o, user_set_o} == 6'b0,
          "R1 control outputs reset", int'({cal_en_o, chan_off_o, mode_ovr_o, done_o, err_o, user_set_o}), 0);

    // R2 refused start
    chan_busy_i = 1'b1;
    start_i = 1'b1;
    @(posedge clk); @(negedge clk);
    start_i = 1'b0;
    check(err_o == 1'b1, "R2 err pulse", int'(err_o), 1);
    check(!chan_off_o && !cal_en_o, "R2 no run", int'({chan_off_o, cal_en_o}), 0);
    @(posedge clk); @(negedge clk);
    check(err_o == 1'b0, "R2 err one cycle", int'(err_o), 0);
    check(!chan_off_o && !cal_en_o, "R2 still idle", int'({chan_off_o, cal_en_o}), 0);
    chan_busy_i = 1'b0;

    // R9 user write
    user_code_i = 5'd7; user_wr_i = 1'b1;
    @(posedge clk); @(negedge clk);
    user_wr_i = 1'b0;
    check(trim_o == 5'd7, "R9 user code loaded", int'(trim_o), 7);
    check(user_set_o == 1'b1, "R9 user flag set", int'(user_set_o), 1);

    // Full run with target 11, settle 2
    run_cal(11, 2, 3'd5, 1'b0);
    check(r_chan_at == 1, "R3 channel disable timing", r_chan_at, 1);
    check(r_cal_at == 1 + D, "R3 cal enable after drop wait", r_cal_at, 1 + D);
    check(r_ovr_ok, "R3 override during calibration", int'(r_ovr_ok), 1);
    check(r_nseq == 5, "R4 candidate count", r_nseq, 5);
    for (int i = 0; i < 5; i++)
      check(r_seq[i] == exp_seq[i], "R4 candidate sequence", r_seq[i], exp_seq[i]);
    check(r_first == r_cal_at + 3, "R5 first hold length", r_first - r_cal_at, 3);
    check(r_cyc == D + 5 * 3 + 1, "R5 run length", r_cyc, D + 16);
    check(r_code == 11, "R7 result target 11", r_code, 11);
    check(r_done_mode == 5 && r_done_ovr == 1, "R8 mode restore", r_done_mode, 5);
    check(r_done_cal == 0 && r_done_off == 0, "R8 path released at done", r_done_cal + r_done_off, 0);
    check(r_done_after == 0, "R8 done one cycle", r_done_after, 0);
    check(trim_o == 5'd11, "R8 code retained", int'(trim_o), 11);
    check(user_set_o == 1'b0, "R9 flag cleared by start", int'(user_set_o), 0);

    // Threshold sweep
    for (int t = 0; t <= 32; t++) begin
      int s;
      s = t % 4;
      exp_code = (t < 1) ? 1 : ((t > 31) ? 31 : t);
      run_cal(t, s, MW'(t % 8), 1'b0);
      check(r_code == exp_code, "R7 R6 final code", r_code, exp_code);
      check(r_cyc == D + 5 * (s + 1) + 1, "R5 run length sweep", r_cyc, D + 5 * (s + 1) + 1);
      check(r_done_mode == t % 8, "R8 mode restore sweep", r_done_mode, t % 8);
      check(r_first == r_cal_at + s + 1, "R5 hold sweep", r_first - r_cal_at, s + 1);
    end

    // R6 bump boundary: target 32 stays at top, target 6 bumps 5 to 6
    run_cal(32, 1, 3'd1, 1'b0);
    check(r_code == 31, "R6 no wrap at top", r_code, 31);
    run_cal(6, 0, 3'd1, 1'b0);
    check(r_code == 6, "R6 bump applied", r_code, 6);

    // R10 pokes during a run
    run_cal(21, 3, 3'd2, 1'b1);
    check(r_code == 21, "R10 result unaffected", r_code, 21);
    check(!r_err_seen, "R10 no error on start during run", int'(r_err_seen), 0);
    check(!r_usr_seen && user_set_o == 1'b0, "R10 user write ignored", int'(r_usr_seen), 0);
    check(r_done_mode == 2, "R10 mode restore", r_done_mode, 2);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule